// File: doc/BRIEF.md
# Supply/Battery Source Selector with Hysteresis

This block decides, once per digitised sample, whether the protected rail should be fed from the main supply or from the backup battery. A converter outside the block delivers unsigned millivolt codes for the main supply, the battery and a separate power-fail sense input, qualified by a one-cycle sample strobe. On each strobe the block updates a registered source state.

It leaves the supply for the battery once the supply has sagged to within 50 mV of the battery. It returns to the supply only after the supply has climbed more than 70 mV above the battery. The 20 mV gap between the two points stops the selector from toggling back and forth while the supply drifts slowly through the crossover.

Alongside the source state the block reports two flags. The first tells the reset logic that the supply code is below the battery code. The second is an active-low power-fail warning. It compares the sense input against a 1300 mV level, and it is held active whenever the battery is feeding the rail. The power switches, the converter and the analog comparators are outside this block.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: While `rst_ni` is low, and afterwards until the first strobe, `on_batt_o`=1, `sup_below_bat_o`=0 and `pwr_warn_no`=0.
- R2: When on main supply (`on_batt_o`=0), a strobe with `vsup_mv_i` < `vbat_mv_i`+50 sets `on_batt_o` to 1.
- R3: When on battery (`on_batt_o`=1), a strobe with `vsup_mv_i` > `vbat_mv_i`+70 clears `on_batt_o` to 0. Any other strobe keeps the battery selected.
- R4: When on main supply, a strobe with `vsup_mv_i` equal to `vbat_mv_i`+50 keeps main. When on battery, a strobe with `vsup_mv_i` equal to `vbat_mv_i`+70 keeps battery.
- R5: All three outputs are registered. They change only at the clock edge where `smp_valid_i`=1, and the new values are visible right after that edge. Input changes without a strobe have no effect.
- R6: On main supply, `pwr_warn_no` is 0 when `pfin_mv_i` < 1300 and 1 when `pfin_mv_i` >= 1300, both taken from the same strobe.
- R7: `pwr_warn_no` is 0 whenever `on_batt_o`=1. This includes every sample where the supply is below the battery.
- R8: `sup_below_bat_o` equals (`vsup_mv_i` < `vbat_mv_i`) of the latest strobe.
- R9: Threshold sums are formed one bit wider than the codes, so battery codes near full scale (8191) never wrap. With `vbat_mv_i`=`vsup_mv_i`=8191 the battery stays selected.
- R10: A monotonic slow sweep of the supply across the battery level gives exactly one source change per direction. Falling, the change happens at the first sample below battery+50. Rising, it happens at the first sample above battery+70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe, one cycle per conversion |
| vsup_mv_i | input | 13 | Main supply code, mV unsigned |
| vbat_mv_i | input | 13 | Battery code, mV unsigned |
| pfin_mv_i | input | 13 | Power-fail sense code, mV unsigned |
| on_batt_o | output | 1 | 1 = rail fed from battery |
| sup_below_bat_o | output | 1 | 1 = supply code below battery code |
| pwr_warn_no | output | 1 | Power-fail warning, active low |

## Verification
A corrupted source state appears on `on_batt_o` right after the next strobe edge. Because the warning is forced active whenever the battery is selected, the same corruption also shows on `pwr_warn_no` in that cycle. Errors in the threshold arithmetic show up only at the exact boundary codes (+50, +70) or near full scale, so the vectors hit those codes exactly. The slow sweep counts source changes, which exposes a missing or inverted hysteresis band within one crossing.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_BATT = 1'b1
  } src_e;
endpackage

// File: rtl/bsw_thresh.sv
module bsw_thresh #(
  parameter int unsigned W       = 13,
  parameter int unsigned FALL_MV = 50,
  parameter int unsigned RISE_MV = 70
) (
  input  logic [W-1:0] vsup_i,
  input  logic [W-1:0] vbat_i,
  output logic         fall_trip_o,
  output logic         rise_ok_o,
  output logic         below_o
);
  localparam int unsigned EW = W + 1;
  localparam logic [EW-1:0] FALL_E = EW'(FALL_MV);
  localparam logic [EW-1:0] RISE_E = EW'(RISE_MV);

  logic [EW-1:0] sup_e, fall_lvl, rise_lvl;

  // widened so battery codes near full scale cannot wrap
  assign sup_e    = {1'b0, vsup_i};
  assign fall_lvl = {1'b0, vbat_i} + FALL_E;
  assign rise_lvl = {1'b0, vbat_i} + RISE_E;

  assign fall_trip_o = sup_e < fall_lvl;
  assign rise_ok_o   = sup_e > rise_lvl;
  assign below_o     = vsup_i < vbat_i;
endmodule

// File: rtl/bsw_fsm.sv
module bsw_fsm
  import bsw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_valid_i,
  input  logic fall_trip_i,
  input  logic rise_ok_i,
  output src_e src_nxt_o,
  output src_e src_q_o
);
  src_e src_q, src_d;

  always_comb begin
    src_d = src_q;
    unique case (src_q)
      SRC_MAIN: if (fall_trip_i) src_d = SRC_BATT;
      SRC_BATT: if (rise_ok_i)   src_d = SRC_MAIN;
      default:  src_d = SRC_BATT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          src_q <= SRC_BATT;
    else if (smp_valid_i) src_q <= src_d;
  end

  assign src_nxt_o = src_d;
  assign src_q_o   = src_q;
endmodule

// File: rtl/bsw_pf.sv
module bsw_pf
  import bsw_pkg::*;
#(
  parameter int unsigned W     = 13,
  parameter int unsigned PF_MV = 1300
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         smp_valid_i,
  input  logic [W-1:0] pfin_i,
  input  src_e         src_nxt_i,
  output logic         warn_no
);
  localparam logic [W-1:0] PF_LVL = W'(PF_MV);

  logic warn_n_d, warn_n_q;

  // comparator disabled (warning forced) whenever battery feeds the rail
  assign warn_n_d = (src_nxt_i == SRC_MAIN) && (pfin_i >= PF_LVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          warn_n_q <= 1'b0;
    else if (smp_valid_i) warn_n_q <= warn_n_d;
  end

  assign warn_no = warn_n_q;
endmodule

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl
  import bsw_pkg::*;
#(
  parameter int unsigned W       = 13,
  parameter int unsigned FALL_MV = 50,
  parameter int unsigned RISE_MV = 70,
  parameter int unsigned PF_MV   = 1300
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         smp_valid_i,
  input  logic [W-1:0] vsup_mv_i,
  input  logic [W-1:0] vbat_mv_i,
  input  logic [W-1:0] pfin_mv_i,
  output logic         on_batt_o,
  output logic         sup_below_bat_o,
  output logic         pwr_warn_no
);
  logic fall_trip, rise_ok, below;
  src_e src_nxt, src_q;
  logic below_q;

  bsw_thresh #(.W(W), .FALL_MV(FALL_MV), .RISE_MV(RISE_MV)) u_thresh (
    .vsup_i      (vsup_mv_i),
    .vbat_i      (vbat_mv_i),
    .fall_trip_o (fall_trip),
    .rise_ok_o   (rise_ok),
    .below_o     (below)
  );

  bsw_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .fall_trip_i (fall_trip),
    .rise_ok_i   (rise_ok),
    .src_nxt_o   (src_nxt),
    .src_q_o     (src_q)
  );

  bsw_pf #(.W(W), .PF_MV(PF_MV)) u_pf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .pfin_i      (pfin_mv_i),
    .src_nxt_i   (src_nxt),
    .warn_no     (pwr_warn_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          below_q <= 1'b0;
    else if (smp_valid_i) below_q <= below;
  end

  assign on_batt_o       = (src_q == SRC_BATT);
  assign sup_below_bat_o = below_q;
endmodule

// File: rtl/bsw_chk.sv
module bsw_chk #(
  parameter int unsigned W       = 13,
  parameter int unsigned FALL_MV = 50,
  parameter int unsigned RISE_MV = 70,
  parameter int unsigned PF_MV   = 1300
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         smp_valid_i,
  input logic [W-1:0] vsup_mv_i,
  input logic [W-1:0] vbat_mv_i,
  input logic [W-1:0] pfin_mv_i,
  input logic         on_batt_o,
  input logic         sup_below_bat_o,
  input logic         pwr_warn_no
);
  logic [W:0] sup_x, fall_x, rise_x;
  assign sup_x  = {1'b0, vsup_mv_i};
  assign fall_x = {1'b0, vbat_mv_i} + (W+1)'(FALL_MV);
  assign rise_x = {1'b0, vbat_mv_i} + (W+1)'(RISE_MV);

  a_r2_leave_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !on_batt_o && sup_x < fall_x) |=> on_batt_o);

  a_r4_keep_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !on_batt_o && !(sup_x < fall_x)) |=> !on_batt_o);

  a_r3_leave_batt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && on_batt_o && sup_x > rise_x) |=> !on_batt_o);

  a_r3_keep_batt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && on_batt_o && !(sup_x > rise_x)) |=> on_batt_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ($stable(on_batt_o) && $stable(sup_below_bat_o) && $stable(pwr_warn_no)));

  a_r7_warn_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_batt_o |-> !pwr_warn_no);

  a_r6_warn_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && pfin_mv_i < W'(PF_MV)) |=> !pwr_warn_no);

  a_r8_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && vsup_mv_i < vbat_mv_i) |=> (sup_below_bat_o && on_batt_o));
endmodule

bind bkup_switch_ctrl bsw_chk #(
  .W(W), .FALL_MV(FALL_MV), .RISE_MV(RISE_MV), .PF_MV(PF_MV)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .smp_valid_i     (smp_valid_i),
  .vsup_mv_i       (vsup_mv_i),
  .vbat_mv_i       (vbat_mv_i),
  .pfin_mv_i       (pfin_mv_i),
  .on_batt_o       (on_batt_o),
  .sup_below_bat_o (sup_below_bat_o),
  .pwr_warn_no     (pwr_warn_no)
);

// File: tb/bkup_switch_ctrl_tb.sv
`timescale 1ns/1ps
module bkup_switch_ctrl_tb;
  localparam int W = 13;
  localparam int NV = 15;

  typedef struct packed {
    logic [12:0] sup;
    logic [12:0] bat;
    logic [12:0] pf;
    logic        e_batt;
    logic        e_below;
    logic        e_warn_n;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{13'd5000, 13'd3000, 13'd2000, 1'b0, 1'b0, 1'b1}, // R3 leave battery
    '{13'd3060, 13'd3000, 13'd2000, 1'b0, 1'b0, 1'b1}, // R2 inside band, stay main
    '{13'd3050, 13'd3000, 13'd2000, 1'b0, 1'b0, 1'b1}, // R4 exact +50 stays main
    '{13'd3049, 13'd3000, 13'd2000, 1'b1, 1'b0, 1'b0}, // R2 trip to battery
    '{13'd3070, 13'd3000, 13'd2000, 1'b1, 1'b0, 1'b0}, // R4 exact +70 stays battery
    '{13'd3071, 13'd3000, 13'd2000, 1'b0, 1'b0, 1'b1}, // R3 back to main
    '{13'd5000, 13'd3000, 13'd1299, 1'b0, 1'b0, 1'b0}, // R6 below level
    '{13'd5000, 13'd3000, 13'd1300, 1'b0, 1'b0, 1'b1}, // R6 at level
    '{13'd2900, 13'd3000, 13'd2000, 1'b1, 1'b1, 1'b0}, // R7 R8 supply below battery
    '{13'd3000, 13'd3000, 13'd2000, 1'b1, 1'b0, 1'b0}, // R8 equal codes
    '{13'd8191, 13'd0,    13'd0,    1'b0, 1'b0, 1'b0}, // R6 main, pf zero
    '{13'd8191, 13'd8191, 13'd8191, 1'b1, 1'b0, 1'b0}, // R9 full scale, no wrap
    '{13'd8191, 13'd8121, 13'd8191, 1'b1, 1'b0, 1'b0}, // R9 sum 8191 not exceeded
    '{13'd100,  13'd20,   13'd5000, 1'b0, 1'b0, 1'b1}, // R3 low codes
    '{13'd100,  13'd51,   13'd5000, 1'b1, 1'b0, 1'b0}  // R2 100 < 101
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp = 1'b0;
  logic [W-1:0] vsup = '0, vbat = '0, pfin = '0;
  logic on_batt, below, warn_n;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bkup_switch_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp),
    .vsup_mv_i(vsup), .vbat_mv_i(vbat), .pfin_mv_i(pfin),
    .on_batt_o(on_batt), .sup_below_bat_o(below), .pwr_warn_no(warn_n)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s batt/below/warn_n act=%b exp=%b", req, act, exp);
    end
  endtask

  // drive on negedge, strobe captured at next posedge, sample after it
  task automatic sample(input logic [12:0] s, input logic [12:0] b, input logic [12:0] p);
    @(negedge clk);
    vsup = s; vbat = b; pfin = p; smp = 1'b1;
    @(negedge clk);
    smp = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int tr_fall, tr_rise, fall_at, rise_at;
    logic prev;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {on_batt, below, warn_n}, 3'b100);
    rst_n = 1'b1;
    vsup = 13'd6000; vbat = 13'd100; pfin = 13'd4000;
    repeat (2) @(negedge clk);
    chk("R1 before first strobe", {on_batt, below, warn_n}, 3'b100);

    for (int i = 0; i < NV; i++) begin
      sample(VEC[i].sup, VEC[i].bat, VEC[i].pf);
      chk($sformatf("R2-table vec%0d", i), {on_batt, below, warn_n},
          {VEC[i].e_batt, VEC[i].e_below, VEC[i].e_warn_n});
    end

    // R5: no strobe, inputs move, outputs hold
    sample(13'd5000, 13'd3000, 13'd2000);
    chk("R5 setup", {on_batt, below, warn_n}, 3'b001);
    @(negedge clk);
    vsup = 13'd10; vbat = 13'd4000; pfin = 13'd0;
    repeat (4) @(negedge clk);
    chk("R5 no strobe hold", {on_batt, below, warn_n}, 3'b001);

    // R10 slow sweep around 3000 mV battery
    sample(13'd3200, 13'd3000, 13'd2000);
    tr_fall = 0; tr_rise = 0; fall_at = -1; rise_at = -1;
    prev = on_batt;
    for (int v = 3200; v >= 2950; v -= 5) begin
      sample(13'(v), 13'd3000, 13'd2000);
      if (on_batt != prev) begin tr_fall++; fall_at = v; end
      prev = on_batt;
    end
    for (int v = 2950; v <= 3200; v += 5) begin
      sample(13'(v), 13'd3000, 13'd2000);
      if (on_batt != prev) begin tr_rise++; rise_at = v; end
      prev = on_batt;
    end
    checks++;
    if (tr_fall != 1 || fall_at != 3045) begin
      fails++;
      $display("FAIL R10 falling act=%0d@%0d exp=1@3045", tr_fall, fall_at);
    end
    checks++;
    if (tr_rise != 1 || rise_at != 3075) begin
      fails++;
      $display("FAIL R10 rising act=%0d@%0d exp=1@3075", tr_rise, rise_at);
    end

    // R1 reset mid-run returns to battery
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", {on_batt, below, warn_n}, 3'b100);
    rst_n = 1'b1;
    sample(13'd3060, 13'd3000, 13'd2000);
    chk("R3 after reset, inside band", {on_batt, below, warn_n}, 3'b100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule